// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the single-cycle combinational datapath of a small 8-bit accumulator processor. The decoder gives it an operation code, one or two byte operands and the current six-bit condition code register. In the same cycle it returns a byte result, a word result and the next condition code value. Unary operations such as shifts, increment or negate act on the first byte operand. Binary operations combine the first byte operand with the second. For load, store and transfer moves, the decoder places the moved value on the first byte operand.

A second adder handles the word operations. These are addition and subtraction on the double accumulator, formed with A as the high byte and B as the low byte, and the zero-extended addition of B to the index register. Every operation has its own rule for each flag: set, clear, update from the result, or keep. The interrupt mask bit passes through unchanged in all cases.

Top module: `acc_alu`

## Requirements
- R1: The condition code layout, bit 5 down to bit 0, is H, I, N, Z, V, C. I always leaves equal to its input. The operation codes are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6, MOV=7, COM=8, NEG=9, CLR=10, INC=11, DEC=12, TST=13, ASL=14, ASR=15, LSR=16, ROL=17, ROR=18, ADDW=19, SUBW=20, ABX=21. Any other code gives zero results and leaves every flag unchanged.
- R2: ADD forms a+b, and ADC forms a+b+C. Both set C to the carry out of bit 7, H to the carry out of bit 3, V to the signed overflow, N to bit 7 and Z when the result is zero.
- R3: SUB forms a-b, SBC forms a-b-C, and NEG forms 0-a. These set C to the borrow and V to the signed overflow, update N and Z, and keep H.
- R4: AND, OR, XOR and MOV (MOV passes a through) update N and Z, clear V, and keep C and H.
- R5: COM inverts a, clears V and sets C. CLR returns 00, sets Z and clears N, V and C. TST returns a, updates N and Z, and clears V and C.
- R6: INC and DEC add or subtract one. V is set only when a is 7F for INC or 80 for DEC. N and Z are updated, and C and H are kept.
- R7: ASL moves bit 7 into C and fills bit 0 with 0. LSR moves bit 0 into C and fills bit 7 with 0. ASR moves bit 0 into C and keeps bit 7.
- R8: ROL and ROR rotate the nine bits formed by C and a: C enters bit 0 or bit 7, and the bit that leaves goes to C.
- R9: After any shift or rotate, V equals N XOR C, N and Z follow the result, and H is kept.
- R10: ADDW and SUBW add or subtract the 16-bit operand on D. The result goes to the word output. C is the carry or borrow out of bit 15, and V, N and Z are updated from the 16-bit result. H is kept.
- R11: ABX adds the zero-extended second byte operand to the 16-bit index value, returns the sum on the word output, and leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (encoding in R1) |
| opa_i | input | DATA_W | First byte operand (A, or the operand of a unary op) |
| opb_i | input | DATA_W | Second byte operand (memory or B) |
| wide_a_i | input | 2*DATA_W | D for word ops, index value for ABX |
| wide_b_i | input | 2*DATA_W | 16-bit memory operand for ADDW/SUBW |
| ccr_i | input | 6 | Current condition codes H,I,N,Z,V,C |
| res_byte_o | output | DATA_W | Byte result |
| res_word_o | output | 2*DATA_W | Word result |
| ccr_o | output | 6 | Next condition codes |

## Verification
The hardest flag conditions to reach are the ones that depend on a single boundary operand value. These are overflow on INC of 7F and DEC of 80, overflow on NEG of 80, half carry from a low-nibble overflow, and a shift whose V is set because N and C differ. The directed tasks supply exactly these operand values. They also preload the incoming flags to the opposite of the expected outcome, so a flag that should be kept or forced is seen to move or stay. The word operations are driven across the 7FFF/8000 and FFFF/0000 boundaries so that carry and overflow out of bit 15 are both seen.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
      OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_MOV  = 5'd7,
      OP_COM  = 5'd8,  OP_NEG  = 5'd9,  OP_CLR  = 5'd10, OP_INC  = 5'd11,
      OP_DEC  = 5'd12, OP_TST  = 5'd13, OP_ASL  = 5'd14, OP_ASR  = 5'd15,
      OP_LSR  = 5'd16, OP_ROL  = 5'd17, OP_ROR  = 5'd18, OP_ADDW = 5'd19,
      OP_SUBW = 5'd20, OP_ABX  = 5'd21
   } alu_op_e;

   typedef enum logic [2:0] {
      SH_ASL = 3'd0, SH_ASR = 3'd1, SH_LSR = 3'd2, SH_ROL = 3'd3, SH_ROR = 3'd4
   } shift_kind_e;

   typedef enum logic [2:0] {
      LG_AND = 3'd0, LG_OR = 3'd1, LG_XOR = 3'd2, LG_MOV = 3'd3, LG_COM = 3'd4
   } logic_kind_e;

   typedef struct packed {
      logic h;
      logic i;
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);

   localparam int MSB = W - 1;

   generate
      if (W < 2) begin : g_chk
         $error("acc_alu_adder: W must be at least 2");
      end

      if (RIPPLE) begin : g_ripple
         logic [W:0] carry;
         assign carry[0] = cin_i;
         for (genvar k = 0; k < W; k++) begin : g_bit
            assign sum_o[k]     = x_i[k] ^ y_i[k] ^ carry[k];
            assign carry[k + 1] = (x_i[k] & y_i[k]) | (carry[k] & (x_i[k] ^ y_i[k]));
         end
         assign cout_o = carry[W];
      end else begin : g_flat
         logic [W:0] wide_sum;
         assign wide_sum = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
         assign sum_o    = wide_sum[W-1:0];
         assign cout_o   = wide_sum[W];
      end
   endgenerate

   assign ovf_o = (x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB]);

endmodule

// File: rtl/acc_alu_shifter.sv
module acc_alu_shifter
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  shift_kind_e  kind_i,
   input  logic [W-1:0] val_i,
   input  logic         cin_i,
   output logic [W-1:0] res_o,
   output logic         cout_o
);

   localparam int MSB = W - 1;

   always_comb begin
      res_o  = val_i;
      cout_o = cin_i;
      case (kind_i)
         SH_ASL: begin res_o = {val_i[MSB-1:0], 1'b0};       cout_o = val_i[MSB]; end
         SH_ASR: begin res_o = {val_i[MSB], val_i[MSB:1]};   cout_o = val_i[0];   end
         SH_LSR: begin res_o = {1'b0, val_i[MSB:1]};         cout_o = val_i[0];   end
         SH_ROL: begin res_o = {val_i[MSB-1:0], cin_i};      cout_o = val_i[MSB]; end
         SH_ROR: begin res_o = {cin_i, val_i[MSB:1]};        cout_o = val_i[0];   end
         default: begin res_o = val_i;                       cout_o = cin_i;      end
      endcase
   end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic_kind_e  kind_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o
);

   always_comb begin
      case (kind_i)
         LG_AND:  res_o = a_i & b_i;
         LG_OR:   res_o = a_i | b_i;
         LG_XOR:  res_o = a_i ^ b_i;
         LG_COM:  res_o = ~a_i;
         default: res_o = a_i;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [4:0]          op_i,
   input  logic [DATA_W-1:0]   opa_i,
   input  logic [DATA_W-1:0]   opb_i,
   input  logic [2*DATA_W-1:0] wide_a_i,
   input  logic [2*DATA_W-1:0] wide_b_i,
   input  logic [5:0]          ccr_i,
   output logic [DATA_W-1:0]   res_byte_o,
   output logic [2*DATA_W-1:0] res_word_o,
   output logic [5:0]          ccr_o
);

   localparam int WW   = 2 * DATA_W;
   localparam int MSB  = DATA_W - 1;
   localparam int WMSB = WW - 1;
   localparam int HB   = DATA_W / 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_chk
         $error("acc_alu: DATA_W must be even and at least 4");
      end
   endgenerate

   alu_op_e op;
   ccr_t    cc_in;
   ccr_t    cc_nx;
   assign op    = alu_op_e'(op_i);
   assign cc_in = ccr_t'(ccr_i);

   // byte adder operand steering
   logic [DATA_W-1:0] ax, ay, asum;
   logic              acin, acout, aovf;

   always_comb begin
      ax   = opa_i;
      ay   = opb_i;
      acin = 1'b0;
      case (op)
         OP_ADC: acin = cc_in.c;
         OP_SUB: begin ay = ~opb_i; acin = 1'b1; end
         OP_SBC: begin ay = ~opb_i; acin = ~cc_in.c; end
         OP_NEG: begin ax = '0; ay = ~opa_i; acin = 1'b1; end
         OP_INC: begin ay = '0; acin = 1'b1; end
         OP_DEC: ay = '1;
         default: ;
      endcase
   end

   acc_alu_adder #(.W(DATA_W), .RIPPLE(RIPPLE)) i_add8 (
      .x_i(ax), .y_i(ay), .cin_i(acin),
      .sum_o(asum), .cout_o(acout), .ovf_o(aovf)
   );

   // word adder operand steering
   logic [WW-1:0] wx, wy, wsum;
   logic          wcin, wcout, wovf;

   always_comb begin
      wx   = wide_a_i;
      wy   = wide_b_i;
      wcin = 1'b0;
      case (op)
         OP_SUBW: begin wy = ~wide_b_i; wcin = 1'b1; end
         OP_ABX:  wy = {{DATA_W{1'b0}}, opb_i};
         default: ;
      endcase
   end

   acc_alu_adder #(.W(WW), .RIPPLE(RIPPLE)) i_add16 (
      .x_i(wx), .y_i(wy), .cin_i(wcin),
      .sum_o(wsum), .cout_o(wcout), .ovf_o(wovf)
   );

   // shifter and logic units
   shift_kind_e       sh_kind;
   logic_kind_e       lg_kind;
   logic [DATA_W-1:0] sh_res, lg_res;
   logic              sh_cout;

   always_comb begin
      case (op)
         OP_ASR:  sh_kind = SH_ASR;
         OP_LSR:  sh_kind = SH_LSR;
         OP_ROL:  sh_kind = SH_ROL;
         OP_ROR:  sh_kind = SH_ROR;
         default: sh_kind = SH_ASL;
      endcase
      case (op)
         OP_AND:  lg_kind = LG_AND;
         OP_OR:   lg_kind = LG_OR;
         OP_XOR:  lg_kind = LG_XOR;
         OP_COM:  lg_kind = LG_COM;
         default: lg_kind = LG_MOV;
      endcase
   end

   acc_alu_shifter #(.W(DATA_W)) i_shift (
      .kind_i(sh_kind), .val_i(opa_i), .cin_i(cc_in.c),
      .res_o(sh_res), .cout_o(sh_cout)
   );

   acc_alu_logic #(.W(DATA_W)) i_logic (
      .kind_i(lg_kind), .a_i(opa_i), .b_i(opb_i), .res_o(lg_res)
   );

   // result select and flag rules
   logic [DATA_W-1:0] rb;
   logic [WW-1:0]     rw;

   always_comb begin
      cc_nx = cc_in;
      rb    = '0;
      rw    = '0;
      case (op)
         OP_ADD, OP_ADC: begin
            rb      = asum;
            cc_nx.h = ax[HB] ^ ay[HB] ^ asum[HB];
            cc_nx.c = acout;
            cc_nx.v = aovf;
         end
         OP_SUB, OP_SBC, OP_NEG: begin
            rb      = asum;
            cc_nx.c = ~acout;
            cc_nx.v = aovf;
         end
         OP_INC, OP_DEC: begin
            rb      = asum;
            cc_nx.v = aovf;
         end
         OP_AND, OP_OR, OP_XOR, OP_MOV: begin
            rb      = lg_res;
            cc_nx.v = 1'b0;
         end
         OP_COM: begin
            rb      = lg_res;
            cc_nx.v = 1'b0;
            cc_nx.c = 1'b1;
         end
         OP_CLR: begin
            rb      = '0;
            cc_nx.v = 1'b0;
            cc_nx.c = 1'b0;
         end
         OP_TST: begin
            rb      = opa_i;
            cc_nx.v = 1'b0;
            cc_nx.c = 1'b0;
         end
         OP_ASL, OP_ASR, OP_LSR, OP_ROL, OP_ROR: begin
            rb      = sh_res;
            cc_nx.c = sh_cout;
            cc_nx.v = sh_res[MSB] ^ sh_cout;
         end
         OP_ADDW, OP_SUBW: begin
            rw      = wsum;
            cc_nx.c = (op == OP_ADDW) ? wcout : ~wcout;
            cc_nx.v = wovf;
            cc_nx.n = wsum[WMSB];
            cc_nx.z = (wsum == '0);
         end
         OP_ABX: rw = wsum;
         default: ;
      endcase
      if (op <= OP_ROR) begin
         cc_nx.n = rb[MSB];
         cc_nx.z = (rb == '0);
      end
   end

   assign res_byte_o = rb;
   assign res_word_o = rw;
   assign ccr_o      = cc_nx;

   // assertions against the arithmetic meaning of each operation
   always_comb begin
      if (op == OP_ADD) begin
         assert_add_carry_R2: assert ({ccr_o[0], res_byte_o} == ({1'b0, opa_i} + {1'b0, opb_i}))
            else $error("R2 add sum/carry mismatch");
      end
      if (op == OP_SUB) begin
         assert_sub_borrow_R3: assert (ccr_o[0] == (opb_i > opa_i))
            else $error("R3 borrow mismatch");
      end
      if (op == OP_AND) begin
         assert_and_clear_v_R4: assert (res_byte_o == (opa_i & opb_i) && ccr_o[1] == 1'b0 && ccr_o[0] == ccr_i[0])
            else $error("R4 and result/flags mismatch");
      end
      if (op == OP_ROL) begin
         assert_rotate_nine_R8: assert ({ccr_o[0], res_byte_o} == {opa_i, ccr_i[0]})
            else $error("R8 rotate mismatch");
      end
      if (op == OP_ABX) begin
         assert_abx_flags_R11: assert (ccr_o == ccr_i && res_word_o == wide_a_i + {{DATA_W{1'b0}}, opb_i})
            else $error("R11 index add mismatch");
      end
      assert_mask_kept_R1: assert (ccr_o[4] == ccr_i[4])
         else $error("R1 mask bit changed");
   end

endmodule

// File: tb/test_acc_alu.sv
module test_acc_alu;
   import acc_alu_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op;
   logic [7:0]  a, b;
   logic [15:0] wa, wb;
   logic [5:0]  cc;
   logic [7:0]  rb;
   logic [15:0] rw;
   logic [5:0]  cco;
   int          n_tests = 0;
   int          n_fail  = 0;
   bit          done    = 1'b0;

   always #10 clk = ~clk;

   acc_alu i_acc_alu (
      .op_i(op), .opa_i(a), .opb_i(b), .wide_a_i(wa), .wide_b_i(wb),
      .ccr_i(cc), .res_byte_o(rb), .res_word_o(rw), .ccr_o(cco)
   );

   task automatic drive(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                        input logic [15:0] p, input logic [15:0] q, input logic [5:0] f);
      @(posedge clk);
      op = o; a = x; b = y; wa = p; wb = q; cc = f;
      @(negedge clk);
   endtask

   task automatic chk8(input string tag, input logic [7:0] er, input logic [5:0] ec);
      n_tests++;
      if (rb !== er || cco !== ec) begin
         n_fail++;
         $display("FAIL %s res=%h exp=%h ccr=%b exp=%b", tag, rb, er, cco, ec);
      end
   endtask

   task automatic chk16(input string tag, input logic [15:0] er, input logic [5:0] ec);
      n_tests++;
      if (rw !== er || cco !== ec) begin
         n_fail++;
         $display("FAIL %s res=%h exp=%h ccr=%b exp=%b", tag, rw, er, cco, ec);
      end
   endtask

   // flag order: H I N Z V C
   task automatic t_idle();
      drive(5'd31, 8'h5A, 8'hA5, 16'h1234, 16'h4321, 6'b101011);
      chk8("R1 undefined code", 8'h00, 6'b101011);
      chk16("R1 undefined code word", 16'h0000, 6'b101011);
   endtask

   task automatic t_add();
      drive(OP_ADD, 8'h0F, 8'h01, 0, 0, 6'b000000); chk8("R2 half carry", 8'h10, 6'b100000);
      drive(OP_ADD, 8'h7F, 8'h01, 0, 0, 6'b010000); chk8("R2 overflow", 8'h80, 6'b111010);
      drive(OP_ADD, 8'hFF, 8'h01, 0, 0, 6'b000000); chk8("R2 carry zero", 8'h00, 6'b100101);
      drive(OP_ADC, 8'h10, 8'h10, 0, 0, 6'b100001); chk8("R2 adc", 8'h21, 6'b000000);
   endtask

   task automatic t_sub();
      drive(OP_SUB, 8'h10, 8'h20, 0, 0, 6'b100000); chk8("R3 borrow keeps H", 8'hF0, 6'b101001);
      drive(OP_SUB, 8'h80, 8'h01, 0, 0, 6'b000000); chk8("R3 overflow", 8'h7F, 6'b000010);
      drive(OP_SBC, 8'h05, 8'h05, 0, 0, 6'b000001); chk8("R3 sbc", 8'hFF, 6'b001001);
      drive(OP_NEG, 8'h80, 8'h00, 0, 0, 6'b000000); chk8("R3 neg 80", 8'h80, 6'b001011);
      drive(OP_NEG, 8'h00, 8'h00, 0, 0, 6'b000001); chk8("R3 neg 00", 8'h00, 6'b000100);
   endtask

   task automatic t_logic();
      drive(OP_AND, 8'hF0, 8'h3C, 0, 0, 6'b000011); chk8("R4 and", 8'h30, 6'b000001);
      drive(OP_OR,  8'h80, 8'h01, 0, 0, 6'b000000); chk8("R4 or", 8'h81, 6'b001000);
      drive(OP_XOR, 8'hAA, 8'hAA, 0, 0, 6'b010001); chk8("R4 xor", 8'h00, 6'b010101);
      drive(OP_MOV, 8'h00, 8'hFF, 0, 0, 6'b100010); chk8("R4 mov", 8'h00, 6'b100100);
   endtask

   task automatic t_unary();
      drive(OP_COM, 8'h0F, 8'h00, 0, 0, 6'b000010); chk8("R5 com", 8'hF0, 6'b001001);
      drive(OP_CLR, 8'h77, 8'h00, 0, 0, 6'b111011); chk8("R5 clr", 8'h00, 6'b110100);
      drive(OP_TST, 8'h80, 8'h00, 0, 0, 6'b000011); chk8("R5 tst", 8'h80, 6'b001000);
   endtask

   task automatic t_incdec();
      drive(OP_INC, 8'h7F, 8'h00, 0, 0, 6'b000001); chk8("R6 inc 7F", 8'h80, 6'b001011);
      drive(OP_INC, 8'hFF, 8'h00, 0, 0, 6'b100000); chk8("R6 inc FF", 8'h00, 6'b100100);
      drive(OP_DEC, 8'h80, 8'h00, 0, 0, 6'b000000); chk8("R6 dec 80", 8'h7F, 6'b000010);
      drive(OP_DEC, 8'h01, 8'h00, 0, 0, 6'b000001); chk8("R6 dec 01", 8'h00, 6'b000101);
   endtask

   task automatic t_shift();
      drive(OP_ASL, 8'h81, 8'h00, 0, 0, 6'b000000); chk8("R7 R9 asl", 8'h02, 6'b000011);
      drive(OP_ASR, 8'h81, 8'h00, 0, 0, 6'b000000); chk8("R7 R9 asr", 8'hC0, 6'b001001);
      drive(OP_LSR, 8'h81, 8'h00, 0, 0, 6'b100000); chk8("R7 R9 lsr", 8'h40, 6'b100011);
      drive(OP_LSR, 8'h01, 8'h00, 0, 0, 6'b000000); chk8("R7 R9 lsr zero", 8'h00, 6'b000111);
   endtask

   task automatic t_rotate();
      drive(OP_ROL, 8'h80, 8'h00, 0, 0, 6'b000000); chk8("R8 rol out", 8'h00, 6'b000111);
      drive(OP_ROL, 8'h01, 8'h00, 0, 0, 6'b000001); chk8("R8 rol in", 8'h03, 6'b000000);
      drive(OP_ROR, 8'h01, 8'h00, 0, 0, 6'b000001); chk8("R8 R9 ror", 8'h80, 6'b001001);
      drive(OP_ROR, 8'h02, 8'h00, 0, 0, 6'b000000); chk8("R8 ror", 8'h01, 6'b000000);
   endtask

   task automatic t_wide();
      drive(OP_ADDW, 0, 0, 16'h7FFF, 16'h0001, 6'b100000); chk16("R10 addw ovf", 16'h8000, 6'b101010);
      drive(OP_ADDW, 0, 0, 16'hFFFF, 16'h0001, 6'b000000); chk16("R10 addw carry", 16'h0000, 6'b000101);
      drive(OP_SUBW, 0, 0, 16'h0000, 16'h0001, 6'b000000); chk16("R10 subw borrow", 16'hFFFF, 6'b001001);
      drive(OP_SUBW, 0, 0, 16'h8000, 16'h0001, 6'b000000); chk16("R10 subw ovf", 16'h7FFF, 6'b000010);
   endtask

   task automatic t_abx();
      drive(OP_ABX, 8'h00, 8'hFF, 16'h12F0, 16'h0000, 6'b101010); chk16("R11 abx", 16'h13EF, 6'b101010);
      drive(OP_ABX, 8'h00, 8'h01, 16'hFFFF, 16'h0000, 6'b010000); chk16("R11 abx wrap", 16'h0000, 6'b010000);
   endtask

   initial begin
      op = 5'd31; a = '0; b = '0; wa = '0; wb = '0; cc = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_unary();
      t_incdec();
      t_shift();
      t_rotate();
      t_wide();
      t_abx();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule